// File: doc/BRIEF.md
# Sixteen-Channel Shared-Counter PWM Generator

This block drives a bank of pulse-width-modulated outputs from a single free-running 12-bit count. A programmable prescaler divides the block clock, which acts as the fixed reference, and each division step advances the shared count by one. Each channel holds a start count and a stop count. Its output is high while the shared count lies in the circular window that begins at the start count and ends before the stop count. Two override bits per channel force the output fully high or fully low.

Software reaches the block through a synchronous byte-wide port with an 8-bit address. Through this port it programs the per-channel counts, a broadcast group that writes every channel at once, two mode registers and the prescale value. The mode registers control a sleep state that freezes the prescaler and count, a restart handshake that resumes counting, output polarity inversion, and the output drive style. Drive style is exposed as a per-pin output enable so that open-drain pads can be built outside the block. New start and stop counts are staged and take effect only when the count wraps, so a single period never mixes old and new values.

Top module: `multi_pwm`

## Requirements
- R1: After reset, every pwmOut bit is 0 and every pwmOe bit is 1. Reads return the following: address 0x00 gives 0x10, address 0x01 gives 0x04, address 0xFE gives PRESCALE_RST (0x1E), and each channel's stop-high byte gives 0x10 (force-low set).
- R2: Channel N uses bytes 0x06+4N to 0x09+4N, in this order: start low, start high, stop low, stop high. Each high byte carries count bits [11:8] in bits [3:0] and the channel's override in bit 4. Bits [7:5] read back as 0.
- R3: With neither override set, the output is high exactly while the count c satisfies start <= c < stop (when start < stop), or c >= start or c < stop (when start > stop). When start equals stop the output is never high. Each period therefore holds (stop - start) mod 4096 high cycles.
- R4: Bit 4 of the start-high byte holds the output high for the whole period. Bit 4 of the stop-high byte holds it low, and it wins when both bits are set. Both override bits act from the cycle after the write.
- R5: Writes to 0xFA, 0xFB, 0xFC and 0xFD (start low, start high, stop low, stop high) update every channel at once. Reads of these addresses return 0.
- R6: One output period lasts (prescale + 1) x 4096 clocks. A write to 0xFE is accepted only while the sleep bit is set and is otherwise ignored.
- R7: Sleep is bit 4 of address 0x00. Setting it freezes the prescaler and the count and drives every output low before inversion. After sleep is cleared the block stays frozen, and bit 7 of 0x00 reads 1, until bit 7 is written as 1 while sleep is already clear.
- R8: Bit 4 of address 0x01 inverts every pwmOut bit.
- R9: Bit 2 of address 0x01 selects the drive style. When it is 1, every pwmOe bit is 1. When it is 0, pwmOe is 1 only on pins whose pwmOut is 0 (open-drain).
- R10: New start and stop counts take effect when the count passes from 4095 to 0, or at once while the block is frozen. A write in the middle of a period does not change that period's output.
- R11: rdData presents the addressed byte on the clock after rdEn is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, registered |
| pwmOut | output | NUM_CH | Channel outputs after inversion |
| pwmOe | output | NUM_CH | Per-pin drive enable |

## Verification
A register write takes effect at the clock edge where it is sampled, and a read returns its byte one edge later. The bench therefore samples rdData at the falling edge that follows the read strobe. Override bits, mode bits and sleep act on the outputs from the next cycle, while new start and stop counts wait for the next wrap. For that reason, duty checks first wait two full periods and then count high cycles over exactly one period, which does not depend on phase. The bench checks exact edges, and the staging of mid-period writes, against a known phase. It finds that phase from one channel programmed to go low only at count 4095, and then counts falling edges from there.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CNT_W = 12;
  localparam logic [7:0] A_MODE1    = 8'h00;
  localparam logic [7:0] A_MODE2    = 8'h01;
  localparam logic [7:0] A_SUB0     = 8'h02;
  localparam logic [7:0] A_SUB1     = 8'h03;
  localparam logic [7:0] A_SUB2     = 8'h04;
  localparam logic [7:0] A_CH_BASE  = 8'h06;
  localparam logic [7:0] A_BC_FIRST = 8'hFA;
  localparam logic [7:0] A_BC_LAST  = 8'hFD;
  localparam logic [7:0] A_PRESCALE = 8'hFE;
  localparam int OVR_BIT     = 4;
  localparam int SLEEP_BIT   = 4;
  localparam int RESTART_BIT = 7;
  localparam int INV_BIT     = 4;
  localparam int TOTEM_BIT   = 2;

  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic       chWr;
    logic       bcWr;
    logic [5:0] wrIdx;
    logic [1:0] wrSel;
    logic [7:0] wrData;
    logic [5:0] rdIdx;
    logic [1:0] rdSel;
    logic       tick;
    logic       run;
    logic       invert;
    logic       totem;
  } strobe_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int          NUM_CH       = 16,
  parameter logic [7:0]  PRESCALE_RST = 8'h1E
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic [7:0] chRdByte,
  output logic [7:0] rdData,
  output strobe_t    strb
);
  localparam logic [8:0] CH_END = 9'(A_CH_BASE) + 9'(4 * NUM_CH);

  logic [6:0] mode1Low;
  logic [7:0] mode2;
  logic [7:0] sub0, sub1, sub2;
  logic [7:0] prescale;
  logic [7:0] preCnt;
  logic       halted;
  logic [7:0] chOff;
  logic       inCh, inBc;
  logic       sleepNow;

  always_comb begin
    chOff    = addr - A_CH_BASE;
    inCh     = (addr >= A_CH_BASE) && ({1'b0, addr} < CH_END);
    inBc     = (addr >= A_BC_FIRST) && (addr <= A_BC_LAST);
    sleepNow = mode1Low[SLEEP_BIT];
  end

  // configuration registers and the restart handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode1Low <= 7'h10;
      mode2    <= 8'h04;
      sub0     <= '0;
      sub1     <= '0;
      sub2     <= '0;
      prescale <= PRESCALE_RST;
      halted   <= 1'b1;
    end else if (wrEn) begin
      case (addr)
        A_MODE1: begin
          mode1Low <= wrData[6:0];
          if (wrData[SLEEP_BIT]) halted <= 1'b1;
          else if (wrData[RESTART_BIT] && !sleepNow) halted <= 1'b0;
        end
        A_MODE2:    mode2 <= wrData;
        A_SUB0:     sub0  <= wrData;
        A_SUB1:     sub1  <= wrData;
        A_SUB2:     sub2  <= wrData;
        A_PRESCALE: if (sleepNow) prescale <= wrData;
        default: ;
      endcase
    end
  end

  // prescaler: one tick every prescale+1 clocks while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (wrEn && addr == A_PRESCALE && sleepNow) preCnt <= '0;
    else if (strb.run) preCnt <= (preCnt == prescale) ? 8'd0 : preCnt + 8'd1;
  end

  always_comb begin
    strb.chWr   = wrEn && inCh;
    strb.bcWr   = wrEn && inBc;
    strb.wrIdx  = chOff[7:2];
    strb.wrSel  = inBc ? (addr[1:0] - 2'd2) : chOff[1:0];
    strb.wrData = wrData;
    strb.rdIdx  = chOff[7:2];
    strb.rdSel  = chOff[1:0];
    strb.run    = !halted && !sleepNow;
    strb.tick   = strb.run && (preCnt == prescale);
    strb.invert = mode2[INV_BIT];
    strb.totem  = mode2[TOTEM_BIT];
  end

  // registered read port, one cycle latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      if (inCh) rdData <= chRdByte;
      else begin
        case (addr)
          A_MODE1:    rdData <= {halted && !sleepNow, mode1Low};
          A_MODE2:    rdData <= mode2;
          A_SUB0:     rdData <= sub0;
          A_SUB1:     rdData <= sub1;
          A_SUB2:     rdData <= sub2;
          A_PRESCALE: rdData <= prescale;
          default:    rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpwm_dp.sv
module mpwm_dp
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [7:0]        chRdByte,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic        wrapLoad;
  logic [31:0] chWords [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strb.tick) cnt <= cnt + 1'b1;
  end

  assign wrapLoad = !strb.run || (strb.tick && cnt == CNT_LAST);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic [CNT_W-1:0] shOn, shOff, actOn, actOff;
    logic             forceOn, forceOff;
    logic             hit, inWin, raw;

    assign hit = strb.bcWr || (strb.chWr && strb.wrIdx == 6'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shOn     <= '0;
        shOff    <= '0;
        forceOn  <= 1'b0;
        forceOff <= 1'b1;
      end else if (hit) begin
        case (strb.wrSel)
          2'd0: shOn[7:0]  <= strb.wrData;
          2'd1: begin
            shOn[11:8] <= strb.wrData[3:0];
            forceOn    <= strb.wrData[OVR_BIT];
          end
          2'd2: shOff[7:0] <= strb.wrData;
          default: begin
            shOff[11:8] <= strb.wrData[3:0];
            forceOff    <= strb.wrData[OVR_BIT];
          end
        endcase
      end
    end

    // compare values move from shadow to active only at wrap or when frozen
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actOn  <= '0;
        actOff <= '0;
      end else if (wrapLoad) begin
        actOn  <= shOn;
        actOff <= shOff;
      end
    end

    always_comb begin
      if (actOn < actOff)      inWin = (cnt >= actOn) && (cnt < actOff);
      else if (actOn > actOff) inWin = (cnt >= actOn) || (cnt < actOff);
      else                     inWin = 1'b0;
      raw = strb.run && !forceOff && (forceOn || inWin);
    end

    assign pwmOut[ch]  = raw ^ strb.invert;
    assign pwmOe[ch]   = strb.totem || !pwmOut[ch];
    assign chWords[ch] = {3'b000, forceOff, shOff[11:8], shOff[7:0],
                          3'b000, forceOn,  shOn[11:8],  shOn[7:0]};
  end

  always_comb begin
    logic [31:0] word;
    word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (strb.rdIdx == 6'(i)) word = chWords[i];
    chRdByte = word[8*strb.rdSel +: 8];
  end
endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
  import mpwm_pkg::*;
#(
  parameter int         NUM_CH       = 16,
  parameter logic [7:0] PRESCALE_RST = 8'h1E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);
  strobe_t          strb;
  logic [7:0]       chRdByte;
  logic [CNT_W-1:0] cnt;

  mpwm_ctrl #(.NUM_CH(NUM_CH), .PRESCALE_RST(PRESCALE_RST)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .chRdByte(chRdByte), .rdData(rdData), .strb(strb)
  );

  mpwm_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .chRdByte(chRdByte),
    .pwmOut(pwmOut), .pwmOe(pwmOe), .cnt(cnt)
  );
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] pwmOe
);
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(cnt)); // R7

  AST_NO_TICK_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> !strb.tick); // R7

  AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.invert) |-> (pwmOut == '0)); // R7

  AST_HALT_INVERTED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && strb.invert) |-> (&pwmOut)); // R8

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6

  AST_TOTEM_OE: assert property (@(posedge clk) disable iff (!rstN)
    strb.totem |-> (&pwmOe)); // R9

  AST_OPEN_DRAIN_OE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.totem |-> ((pwmOe & pwmOut) == '0)); // R9
endmodule

bind multi_pwm mpwm_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt),
  .pwmOut(pwmOut), .pwmOe(pwmOe)
);

// File: tb/multi_pwm_test.sv
module multi_pwm_test;
  localparam int NCH = 16;
  localparam int PER = 4096;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]     addr = '0, wrData = '0;
  logic [7:0]     rdData;
  logic [NCH-1:0] pwmOut, pwmOe;

  int checks = 0;
  int errors = 0;
  int highs [NCH];
  bit done = 1'b0;

  // channel, start, stop, expected high cycles per period
  localparam int VEC [6][4] = '{
    '{0,    0, 2048, 2048},
    '{1,  100,  101,    1},
    '{2, 4000,   96,  192},
    '{3,  500,  500,    0},
    '{7, 1024, 3072, 2048},
    '{15,   0, 4095, 4095}
  };

  multi_pwm uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R11: byte due at the falling edge after the sampling edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setCh(input int ch, input int on, input int off);
    wr(8'(6 + 4 * ch), 8'(on));
    wr(8'(7 + 4 * ch), 8'(on >> 8));
    wr(8'(8 + 4 * ch), 8'(off));
    wr(8'(9 + 4 * ch), 8'(off >> 8));
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < NCH; c++) highs[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwmOut[c]) highs[c]++;
    end
  endtask

  // count reaches 4095 at the falling edge where channel 15 reads low
  task automatic syncWrap();
    @(negedge clk);
    while (pwmOut[15]) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwmOut", int'(pwmOut), 0);
    check("R1 pwmOe", int'(pwmOe), 16'hFFFF);
    rd(8'h00, d); check("R1 mode1", d, 8'h10);
    rd(8'h01, d); check("R1 mode2", d, 8'h04);
    rd(8'hFE, d); check("R1 prescale", d, 8'h1E);
    rd(8'h09, d); check("R1 ch0 stop-high", d, 8'h10);

    // R6 prescale accepted in sleep; R7 restart handshake
    wr(8'hFE, 8'h00);
    rd(8'hFE, d); check("R6 prescale write in sleep", d, 0);
    wr(8'h00, 8'h00);
    rd(8'h00, d); check("R7 restart pending", d, 8'h80);
    for (int v = 0; v < 6; v++) setCh(VEC[v][0], VEC[v][1], VEC[v][2]);
    measure(300);
    check("R7 frozen before restart ch0", highs[0], 0);
    wr(8'h00, 8'h80);
    rd(8'h00, d); check("R7 running", d, 8'h00);

    // R3 duty table
    repeat (2 * PER) @(negedge clk);
    measure(PER);
    for (int v = 0; v < 6; v++) check("R3 duty", highs[VEC[v][0]], VEC[v][3]);
    check("R1 untouched ch5 stays low", highs[5], 0);

    // R6 prescale write ignored while running
    wr(8'hFE, 8'h55);
    rd(8'hFE, d); check("R6 prescale ignored", d, 0);

    // R2 byte layout
    rd(8'h0F, d); check("R2 ch2 start-high", d, 8'h0F);
    rd(8'h0E, d); check("R2 ch2 start-low", d, 8'hA0);
    rd(8'h11, d); check("R2 ch2 stop-high", d, 8'h00);
    rd(8'h44, d); check("R2 ch15 stop-low", d, 8'hFF);

    // R3 exact edges of ch7 (1024..3071)
    syncWrap();
    repeat (1024) @(negedge clk);
    check("R3 ch7 before start", int'(pwmOut[7]), 0);
    @(negedge clk);
    check("R3 ch7 at start", int'(pwmOut[7]), 1);
    repeat (2047) @(negedge clk);
    check("R3 ch7 last high", int'(pwmOut[7]), 1);
    @(negedge clk);
    check("R3 ch7 at stop", int'(pwmOut[7]), 0);

    // R10 mid-period write is staged
    syncWrap();
    repeat (200) @(negedge clk);
    setCh(1, 0, 2048);
    measure(1000);
    check("R10 staged ch1", highs[1], 0);
    repeat (2 * PER) @(negedge clk);
    measure(PER);
    check("R10 applied ch1", highs[1], 2048);

    // R4 overrides
    wr(8'h13, 8'h11);
    measure(PER);
    check("R4 force on", highs[3], PER);
    wr(8'h15, 8'h11);
    measure(PER);
    check("R4 force off wins", highs[3], 0);

    // R5 broadcast
    wr(8'hFA, 8'h00); wr(8'hFB, 8'h00); wr(8'hFC, 8'h00); wr(8'hFD, 8'h04);
    rd(8'hFD, d); check("R5 broadcast reads zero", d, 0);
    rd(8'h2D, d); check("R5 ch9 stop-high", d, 8'h04);
    repeat (2 * PER) @(negedge clk);
    measure(PER);
    bad = 0;
    for (int c = 0; c < NCH; c++) if (highs[c] != 1024) bad++;
    check("R5 all channels 1024", bad, 0);

    // R8 inversion
    wr(8'h01, 8'h14);
    measure(PER);
    check("R8 inverted ch0", highs[0], PER - 1024);

    // R9 open drain
    wr(8'h01, 8'h00);
    bad = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pwmOe !== ~pwmOut) bad++;
    end
    check("R9 open-drain enable", bad, 0);
    wr(8'h01, 8'h04);
    @(negedge clk);
    check("R9 totem enable", int'(pwmOe), 16'hFFFF);

    // R7 sleep, R6 period with prescale 1
    wr(8'h00, 8'h10);
    rd(8'h00, d); check("R7 sleep readback", d, 8'h10);
    measure(300);
    bad = 0;
    for (int c = 0; c < NCH; c++) bad += highs[c];
    check("R7 outputs low in sleep", bad, 0);
    wr(8'hFE, 8'h01);
    rd(8'hFE, d); check("R6 prescale 1", d, 1);
    wr(8'h00, 8'h00);
    wr(8'h00, 8'h80);
    repeat (4 * PER) @(negedge clk);
    measure(2 * PER);
    check("R6 doubled period ch0", highs[0], 2048);
    check("R6 doubled period ch12", highs[12], 2048);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule